// File: doc/BRIEF.md
# Line Thermal Print Head Controller

This block feeds a line thermal print head of 1280 dots. The head is wired as 20 ports. Each port holds a 64-bit serial shift register and a latch behind it. All ports share one shift clock, one latch line and one strobe line, and each port has its own serial data line. A host writes one line of dots into an internal line buffer through a plain word-write port. It then pulses `start`, and the controller runs a three-phase sequence. First it shifts 64 bits into all 20 ports in parallel. Then it pulses the active-low latch. Last, it holds the strobe high for a programmed heating time, during which every latched one heats its dot.

The shift clock runs at a programmable divide of the system clock. The latch width and the heating time are also programmable. All three settings are sampled when `start` is accepted. `busy` covers the whole sequence, and a single-cycle `done` marks the end of the strobe. Once the line is latched, the buffer may be rewritten for the next line while the current line is still heating.

Top module: `thermal_line_ctrl`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` bit i at dot index `wr_addr`*16+i (16-bit words, addresses 0 to 79). A write to an address of 80 or more changes no dot.
- R2: `head_data`[p] carries dot p*64+k for bit k, with bit 63 sent first and bit 0 last. All 20 ports change in the same cycle.
- R3: With H = max(`div_half`,1), the shift clock is low for H cycles and then high for H cycles for each bit, and gives exactly 64 rising edges per line. Data changes only in the cycle in which the clock falls, or when the line starts. The first rise comes H cycles after the cycle that accepts `start`.
- R4: `head_latch_n` goes low in the cycle in which the 64th clock pulse falls. It stays low for max(`latch_len`,1) cycles, and the shift clock stays low during that time.
- R5: `head_strobe` goes high in the cycle in which the latch returns high and stays high for `heat_time` cycles. A `heat_time` of 0 produces no strobe.
- R6: `done` is high for exactly one cycle. It rises in the cycle in which the strobe falls, or in the cycle after the latch ends when `heat_time` is 0. `busy` is high from the cycle after `start` is accepted until `done`, and low when `done` is high.
- R7: A `start` pulse given while `busy` is high is ignored. The timing of the running line is unchanged.
- R8: The latch is never low while the strobe is high.
- R9: While `rst_n` is low, and at once when it goes low, the strobe is low, the latch is high, the shift clock is low, and `busy` and `done` are low.
- R10: Buffer writes made while the strobe is active do not change the line that is heating. The next line shifts the new data.
- R11: `div_half`, `latch_len` and `heat_time` are sampled when `start` is accepted. Later changes to these inputs do not affect the running line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Line buffer word write strobe |
| wr_addr | input | 7 | Word address, 0 to 79 valid |
| wr_data | input | 16 | Word data, bit i is dot addr*16+i |
| start | input | 1 | Begin printing the buffered line |
| div_half | input | 8 | Shift clock half period in system clocks (0 means 1) |
| latch_len | input | 8 | Latch pulse width in system clocks (0 means 1) |
| heat_time | input | 16 | Strobe width in system clocks (0 means no strobe) |
| busy | output | 1 | Line sequence in progress |
| done | output | 1 | One-cycle pulse at the end of the line |
| head_clk | output | 1 | Shared shift clock to the head |
| head_latch_n | output | 1 | Shared active-low latch pulse |
| head_strobe | output | 1 | Shared active-high heater enable |
| head_data | output | 20 | Serial data, one line per port |

## Verification
Let cycle c be the value the outputs hold after the c-th clock edge after the edge that accepts `start`. Then the shift clock is (c/H) mod 2 for c < 128H, and the data presented is bit 63-c/(2H). The latch is low for 128H ≤ c < 128H+L, and the strobe is high for the following `heat_time` cycles. `done` falls due at c = 128H+L+`heat_time`, in the same cycle that `busy` drops. The bench drives inputs and samples outputs on the falling clock edge, and compares every sampled cycle against these formulas. A separate head model catches the data on each shift clock rise and snapshots it at the latch fall, so that bit order and port mapping are checked independently of the timing formulas.

// File: rtl/thp_pkg.sv
package thp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SHIFT  = 2'd1,
    PH_LATCH  = 2'd2,
    PH_STROBE = 2'd3
  } phase_t;

endpackage

// File: rtl/thp_rst_sync.sv
module thp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/thp_line_buf.sv
module thp_line_buf #(
  parameter int PORTS  = 20,
  parameter int BITS   = 64,
  parameter int WORD_W = 16,
  localparam int DOTS  = PORTS * BITS,
  localparam int WORDS = DOTS / WORD_W,
  localparam int AW    = $clog2(WORDS),
  localparam int IW    = $clog2(BITS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [PORTS-1:0]  rd_bits
);

  logic [WORD_W-1:0] mem_q [WORDS];
  logic [DOTS-1:0]   dots;
  logic              wr_hit;

  // clock enable: only in-range addresses touch storage
  assign wr_hit = wr_en && (int'(wr_addr) < WORDS);

  always_ff @(posedge clk) begin
    if (wr_hit) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_flat
    assign dots[w*WORD_W +: WORD_W] = mem_q[w];
  end

  // one read mux per port, all indexed by the same bit position
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [BITS-1:0] slice;
    assign slice      = dots[p*BITS +: BITS];
    assign rd_bits[p] = slice[rd_idx];
  end

endmodule

// File: rtl/thp_sequencer.sv
module thp_sequencer
  import thp_pkg::*;
#(
  parameter int PORTS  = 20,
  parameter int BITS   = 64,
  parameter int DIV_W  = 8,
  parameter int LAT_W  = 8,
  parameter int HEAT_W = 16,
  localparam int IW    = $clog2(BITS),
  localparam int CW0   = (DIV_W > LAT_W) ? DIV_W : LAT_W,
  localparam int CNT_W = (HEAT_W > CW0) ? HEAT_W : CW0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  div_half,
  input  logic [LAT_W-1:0]  latch_len,
  input  logic [HEAT_W-1:0] heat_time,
  input  logic [PORTS-1:0]  port_bits,
  output logic [IW-1:0]     rd_idx,
  output logic              busy,
  output logic              done,
  output logic              head_clk,
  output logic              head_latch_n,
  output logic              head_strobe,
  output logic [PORTS-1:0]  head_data
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t             phase_q,  phase_d;
  logic [CNT_W-1:0]   cnt_q,    cnt_d;
  logic [IW-1:0]      idx_q,    idx_d;
  logic               hi_q,     hi_d;
  logic [DIV_W-1:0]   half_q,   half_d;
  logic [LAT_W-1:0]   llen_q,   llen_d;
  logic [HEAT_W-1:0]  heat_q,   heat_d;
  logic               busy_q,   busy_d;
  logic               done_q,   done_d;
  logic               sclk_q,   sclk_d;
  logic               latn_q,   latn_d;
  logic               stb_q,    stb_d;
  logic [PORTS-1:0]   data_q,   data_d;

  logic half_end, latch_end, heat_end;

  assign half_end  = (cnt_q == CNT_W'(half_q) - ONE);
  assign latch_end = (cnt_q == CNT_W'(llen_q) - ONE);
  assign heat_end  = (cnt_q == CNT_W'(heat_q) - ONE);

  // buffer position to present next: top bit at line start, then one lower
  assign rd_idx = (phase_q == PH_IDLE) ? IW'(BITS - 1) : (idx_q - IW'(1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    hi_d    = hi_q;
    half_d  = half_q;
    llen_d  = llen_q;
    heat_d  = heat_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    sclk_d  = sclk_q;
    latn_d  = latn_q;
    stb_d   = stb_q;
    data_d  = data_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SHIFT;
          busy_d  = 1'b1;
          half_d  = (div_half == '0) ? DIV_W'(1) : div_half;
          llen_d  = (latch_len == '0) ? LAT_W'(1) : latch_len;
          heat_d  = heat_time;
          idx_d   = IW'(BITS - 1);
          cnt_d   = '0;
          hi_d    = 1'b0;
          sclk_d  = 1'b0;
          data_d  = port_bits;
        end
      end
      PH_SHIFT: begin
        if (half_end) begin
          cnt_d = '0;
          if (!hi_q) begin
            hi_d   = 1'b1;
            sclk_d = 1'b1;
          end else begin
            hi_d   = 1'b0;
            sclk_d = 1'b0;
            if (idx_q == '0) begin
              phase_d = PH_LATCH;
              latn_d  = 1'b0;
            end else begin
              idx_d  = idx_q - IW'(1);
              data_d = port_bits;
            end
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      PH_LATCH: begin
        if (latch_end) begin
          cnt_d  = '0;
          latn_d = 1'b1;
          if (heat_q == '0) begin
            phase_d = PH_IDLE;
            busy_d  = 1'b0;
            done_d  = 1'b1;
          end else begin
            phase_d = PH_STROBE;
            stb_d   = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      PH_STROBE: begin
        if (heat_end) begin
          cnt_d   = '0;
          stb_d   = 1'b0;
          phase_d = PH_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      hi_q    <= 1'b0;
      half_q  <= DIV_W'(1);
      llen_q  <= LAT_W'(1);
      heat_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sclk_q  <= 1'b0;
      latn_q  <= 1'b1;
      stb_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      hi_q    <= hi_d;
      half_q  <= half_d;
      llen_q  <= llen_d;
      heat_q  <= heat_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      sclk_q  <= sclk_d;
      latn_q  <= latn_d;
      stb_q   <= stb_d;
      data_q  <= data_d;
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign head_clk     = sclk_q;
  assign head_latch_n = latn_q;
  assign head_strobe  = stb_q;
  assign head_data    = data_q;

endmodule

// File: rtl/thermal_line_ctrl.sv
module thermal_line_ctrl #(
  parameter int PORTS  = 20,
  parameter int BITS   = 64,
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8,
  parameter int LAT_W  = 8,
  parameter int HEAT_W = 16,
  localparam int DOTS  = PORTS * BITS,
  localparam int WORDS = DOTS / WORD_W,
  localparam int AW    = $clog2(WORDS),
  localparam int IW    = $clog2(BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic [DIV_W-1:0]  div_half,
  input  logic [LAT_W-1:0]  latch_len,
  input  logic [HEAT_W-1:0] heat_time,
  output logic              busy,
  output logic              done,
  output logic              head_clk,
  output logic              head_latch_n,
  output logic              head_strobe,
  output logic [PORTS-1:0]  head_data
);

  logic             rst_n_int;
  logic [IW-1:0]    rd_idx;
  logic [PORTS-1:0] port_bits;

  thp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  thp_line_buf #(
    .PORTS (PORTS),
    .BITS  (BITS),
    .WORD_W(WORD_W)
  ) u_buf (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_idx (rd_idx),
    .rd_bits(port_bits)
  );

  thp_sequencer #(
    .PORTS (PORTS),
    .BITS  (BITS),
    .DIV_W (DIV_W),
    .LAT_W (LAT_W),
    .HEAT_W(HEAT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start       (start),
    .div_half    (div_half),
    .latch_len   (latch_len),
    .heat_time   (heat_time),
    .port_bits   (port_bits),
    .rd_idx      (rd_idx),
    .busy        (busy),
    .done        (done),
    .head_clk    (head_clk),
    .head_latch_n(head_latch_n),
    .head_strobe (head_strobe),
    .head_data   (head_data)
  );

endmodule

// File: rtl/thp_line_ctrl_chk.sv
module thp_line_ctrl_chk #(
  parameter int PORTS = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             head_clk,
  input logic             head_latch_n,
  input logic             head_strobe,
  input logic [PORTS-1:0] head_data
);

  // R8
  latch_vs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_strobe |-> head_latch_n);

  // R4
  clk_low_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !head_latch_n |-> !head_clk);

  // R3
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(head_clk) |-> $stable(head_data));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_clk && $past(head_clk)) |-> $stable(head_data));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5
  strobe_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(head_strobe) |-> done);

  // R7
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

endmodule

bind thermal_line_ctrl thp_line_ctrl_chk #(.PORTS(PORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .head_clk    (head_clk),
  .head_latch_n(head_latch_n),
  .head_strobe (head_strobe),
  .head_data   (head_data)
);

// File: tb/thermal_line_ctrl_test.sv
module thermal_line_ctrl_test;

  localparam int PORTS = 20;
  localparam int BITS  = 64;
  localparam int WW    = 16;
  localparam int DOTS  = PORTS * BITS;
  localparam int WORDS = DOTS / WW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [6:0]    wr_addr;
  logic [15:0]   wr_data;
  logic          start;
  logic [7:0]    div_half;
  logic [7:0]    latch_len;
  logic [15:0]   heat_time;
  logic          busy, done, head_clk, head_latch_n, head_strobe;
  logic [PORTS-1:0] head_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [DOTS-1:0] buf_m;
  logic [DOTS-1:0] cur_line;
  logic [BITS-1:0] sr_m  [PORTS];
  logic [BITS-1:0] lat_m [PORTS];

  always #5 clk = ~clk;

  thermal_line_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .div_half(div_half),
    .latch_len(latch_len), .heat_time(heat_time), .busy(busy),
    .done(done), .head_clk(head_clk), .head_latch_n(head_latch_n),
    .head_strobe(head_strobe), .head_data(head_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_word(input int a, input logic [15:0] d);
    wr_en   = 1'b1;
    wr_addr = 7'(a);
    wr_data = d;
    if (a < WORDS) buf_m[a*WW +: WW] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill_random();
    for (int a = 0; a < WORDS; a++) write_word(a, 16'($urandom));
  endtask

  function automatic int line_diff();
    int n = 0;
    for (int p = 0; p < PORTS; p++)
      for (int k = 0; k < BITS; k++)
        if (lat_m[p][k] !== cur_line[p*BITS + k]) n++;
    return n;
  endfunction

  // runs one line; called at a falling edge with the design idle
  task automatic run_line(input int hh, input int ll, input int tt,
                          input bit poke_start, input bit write_next,
                          input bit change_cfg);
    int h  = (hh == 0) ? 1 : hh;
    int l  = (ll == 0) ? 1 : ll;
    int sh_end  = 2 * BITS * h;
    int lat_end = sh_end + l;
    int fin     = lat_end + tt;
    int m_clk = 0, m_dat = 0, m_lat = 0, m_stb = 0, m_done = 0, m_busy = 0;
    int rises = 0, overlap = 0, wi = 0;
    logic prev_clk = 1'b0;
    logic prev_lat = 1'b1;
    div_half  = 8'(hh);
    latch_len = 8'(ll);
    heat_time = 16'(tt);
    cur_line  = buf_m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= fin; c++) begin
      logic e_clk, e_lat, e_stb;
      e_clk = (c < sh_end) ? 1'((c / h) % 2) : 1'b0;
      e_lat = !((c >= sh_end) && (c < lat_end));
      e_stb = (c >= lat_end) && (c < fin);
      if (head_clk !== e_clk) m_clk++;
      if (head_latch_n !== e_lat) m_lat++;
      if (head_strobe !== e_stb) m_stb++;
      if (done !== (c == fin)) m_done++;
      if (busy !== (c < fin)) m_busy++;
      if (head_strobe && !head_latch_n) overlap++;
      if (c < sh_end) begin
        int k = BITS - 1 - c / (2 * h);
        for (int p = 0; p < PORTS; p++)
          if (head_data[p] !== cur_line[p*BITS + k]) m_dat++;
      end
      if (head_clk && !prev_clk) begin
        rises++;
        for (int p = 0; p < PORTS; p++) sr_m[p] = {sr_m[p][BITS-2:0], head_data[p]};
      end
      if (!head_latch_n && prev_lat)
        for (int p = 0; p < PORTS; p++) lat_m[p] = sr_m[p];
      prev_clk = head_clk;
      prev_lat = head_latch_n;
      if (c == fin) break;
      // drive for the next cycle
      start = poke_start && (c == 10);
      if (change_cfg && c == 5) begin
        div_half  = 8'(h + 3);
        latch_len = 8'(l + 5);
        heat_time = 16'(tt + 7);
      end
      if (write_next && e_stb && (c + 1 < fin) && wi < WORDS) begin
        wr_en   = 1'b1;
        wr_addr = 7'(wi);
        wr_data = 16'($urandom);
        buf_m[wi*WW +: WW] = wr_data;
        wi++;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    start = 1'b0;
    chk(m_clk == 0,  "R3", "shift clock mismatched cycles", m_clk, 0);
    chk(rises == BITS, "R3", "shift clock rises", rises, BITS);
    chk(m_dat == 0,  "R2", "data bit mismatches", m_dat, 0);
    chk(line_diff() == 0, "R2", "latched dot mismatches", line_diff(), 0);
    chk(m_lat == 0,  "R4", "latch mismatched cycles", m_lat, 0);
    chk(m_stb == 0,  "R5", "strobe mismatched cycles", m_stb, 0);
    chk(m_done == 0, "R6", "done mismatched cycles", m_done, 0);
    chk(m_busy == 0, "R6", "busy mismatched cycles", m_busy, 0);
    chk(overlap == 0, "R8", "latch low during strobe", overlap, 0);
    if (poke_start) chk(m_clk + m_busy == 0, "R7", "timing after ignored start", m_clk + m_busy, 0);
    if (change_cfg) chk(m_stb + m_lat == 0, "R11", "timing after config change", m_stb + m_lat, 0);
    @(negedge clk);
    chk(done === 1'b0, "R6", "done after pulse", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; start = 1'b0;
    div_half = 8'd1; latch_len = 8'd1; heat_time = 16'd0;
    buf_m = '0;
    for (int p = 0; p < PORTS; p++) begin sr_m[p] = '0; lat_m[p] = '0; end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(head_strobe === 1'b0 && head_latch_n === 1'b1 && head_clk === 1'b0,
        "R9", "head lines in reset", {head_strobe, head_latch_n, head_clk}, 3'b010);
    chk(busy === 1'b0 && done === 1'b0, "R9", "busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 directed pattern: alternating words, then an out-of-range write
    for (int a = 0; a < WORDS; a++) write_word(a, (a % 2 == 0) ? 16'hA5C3 : 16'h0FF1);
    write_word(100, 16'hFFFF);
    write_word(127, 16'h0000);
    run_line(1, 2, 5, 1'b0, 1'b0, 1'b0);

    // R1 random line, divide 0 treated as 1, latch 0 treated as 1
    fill_random();
    run_line(0, 0, 3, 1'b0, 1'b0, 1'b0);

    // R7 start pulse during shifting is ignored
    fill_random();
    run_line(2, 3, 10, 1'b1, 1'b0, 1'b0);

    // R10 next line written during heating, R11 config change mid-line
    fill_random();
    run_line(1, 4, 100, 1'b0, 1'b1, 1'b1);
    run_line(3, 1, 20, 1'b0, 1'b0, 1'b0);

    // R5 zero heat time suppresses strobe
    fill_random();
    run_line(1, 3, 0, 1'b0, 1'b0, 1'b0);

    // constrained random lines
    for (int i = 0; i < 3; i++) begin
      fill_random();
      run_line(int'($urandom_range(1, 4)), int'($urandom_range(1, 6)),
               int'($urandom_range(0, 40)), 1'b0, (i == 1), 1'b0);
    end

    // R10 final run confirms data written during last heating
    run_line(1, 1, 2, 1'b0, 1'b0, 1'b0);

    // R9 reset while strobe active
    div_half = 8'd1; latch_len = 8'd1; heat_time = 16'd50;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2 * BITS + 10) @(negedge clk);
    chk(head_strobe === 1'b1, "R5", "strobe active before reset", int'(head_strobe), 1);
    rst_n = 1'b0;
    #1;
    chk(head_strobe === 1'b0 && head_latch_n === 1'b1 && head_clk === 1'b0 && busy === 1'b0,
        "R9", "immediate idle on reset", {head_strobe, head_latch_n, head_clk, busy}, 4'b0100);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && head_strobe === 1'b0, "R9", "idle after reset release",
        {busy, head_strobe}, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog expired actual busy=%0d expected done", int'(busy));
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule